// File: doc/BRIEF.md
# SPI Pad Timing Adjuster

This block sits between a serial-peripheral engine and the pads of a master port. It moves the point at which outgoing data changes and the point at which incoming data is sampled, both counted in module clock cycles. At high bit rates the round trip through pads and board traces can be longer than half a bit time. In that case, sampling on the nominal serial clock edge takes the wrong bit. Software compensates by writing three 2-bit fields from a register: an output delay, an input delay and a capture point.

The engine supplies a shift strobe with the bit to transmit, and a sample-ahead strobe. The sample-ahead strobe pulses two module cycles before the nominal sampling edge. Because of that lead, the capture point can be placed up to two cycles ahead of the nominal edge or one cycle after it. The receive result comes out as a bit plus a one-cycle valid pulse.

The receive side is a stream with valid only. A serial line cannot be stalled, so there is no ready. The consumer must take every bit in the cycle its valid pulse is high. Strobes must be at least four module cycles apart, which means a clock divide ratio of four or more. The three fields must be held steady while a transfer is running.

Top module: `spi_iodelay`

## Requirements
- R1: After reset, `mosi`, `rx_bit` and `rx_valid` are low and every delay stage holds zero.
- R2: If `tx_shift` is high at a clock edge S, `mosi` takes the `tx_bit` value sampled there at edge S + `mo_dly` (0 to 3). When `tx_shift` is low, changes on `tx_bit` have no effect on `mosi`.
- R3: The captured bit is the `miso` level sampled `mi_dly` edges (0 to 3) before the capture edge.
- R4: If `smp_pre` is high at edge E, capture happens at edge E + `cap_sel`. The encodings are: 0 = two cycles ahead of the nominal edge (E), 1 = one ahead, 2 = nominal (E+2), 3 = one cycle late.
- R5: Each capture raises `rx_valid` for exactly one cycle, the cycle after the capture edge. `rx_bit` holds its value between captures.
- R6: With strobes spaced four cycles apart and the latest capture point, every strobe still yields exactly one separate valid pulse, carrying its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mo_dly | input | SEL_W | Output delay in cycles |
| mi_dly | input | SEL_W | Input delay in cycles |
| cap_sel | input | SEL_W | Capture point code |
| tx_shift | input | 1 | Engine strobe: new transmit bit present |
| tx_bit | input | 1 | Transmit bit from engine |
| mosi | output | 1 | Retimed outgoing data |
| smp_pre | input | 1 | Strobe two cycles before nominal sampling edge |
| miso | input | 1 | Raw incoming data pin |
| rx_bit | output | 1 | Captured bit |
| rx_valid | output | 1 | One-cycle pulse marking a new captured bit |

## Verification
The bench uses the default field width of 2. This makes every delay from 0 to 3 and all four capture codes reachable.

It drives `miso` from a known function of the edge number, so adjacent edges mostly carry different levels. An off-by-one in the input delay or the capture point therefore changes the captured bit. The bench also checks the edge on which `rx_valid` appears.

Strobe spacing is swept down to the four-cycle minimum together with the late capture code.

// File: rtl/spi_iod_pkg.sv
package spi_iod_pkg;
  localparam int SEL_W_DEF = 2;

  typedef enum logic [1:0] {
    CAP_AHEAD2  = 2'd0,
    CAP_AHEAD1  = 2'd1,
    CAP_NOMINAL = 2'd2,
    CAP_LATE1   = 2'd3
  } cap_pt_e;
endpackage

// File: rtl/iod_tapline.sv
module iod_tapline #(
  parameter int W     = 1,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);
  localparam int DEPTH = (1 << SEL_W) - 1;
  localparam int NTAP  = DEPTH + 1;

  logic [W-1:0] stg  [DEPTH];
  logic [W-1:0] taps [NTAP];
  logic         live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
      live <= 1'b0;
    end else begin
      stg[0] <= din;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
      live <= 1'b1;
    end
  end

  assign taps[0] = din;
  generate
    for (genvar g = 1; g < NTAP; g++) begin : g_tap
      assign taps[g] = stg[g-1];
    end
  endgenerate

  assign dout = taps[sel];

  AST_TAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && sel == SEL_W'(1) && $past(sel) == SEL_W'(1)) |-> dout == $past(din)); // R3
endmodule

// File: rtl/iod_capture.sv
module iod_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic din,
  output logic bit_o,
  output logic vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= take;
      if (take) bit_o <= din;
    end
  end

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(bit_o)); // R5
endmodule

// File: rtl/spi_iodelay.sv
module spi_iodelay #(
  parameter int SEL_W = spi_iod_pkg::SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] mo_dly,
  input  logic [SEL_W-1:0] mi_dly,
  input  logic [SEL_W-1:0] cap_sel,
  input  logic             tx_shift,
  input  logic             tx_bit,
  output logic             mosi,
  input  logic             smp_pre,
  input  logic             miso,
  output logic             rx_bit,
  output logic             rx_valid
);
  import spi_iod_pkg::*;

  logic tx_hold;
  logic miso_tap;
  logic take;
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_hold <= 1'b0;
      live    <= 1'b0;
    end else begin
      live <= 1'b1;
      if (tx_shift) tx_hold <= tx_bit;
    end
  end

  iod_tapline #(.W(1), .SEL_W(SEL_W)) u_mo_line (
    .clk(clk), .rst_n(rst_n), .sel(mo_dly), .din(tx_hold), .dout(mosi)
  );

  iod_tapline #(.W(1), .SEL_W(SEL_W)) u_mi_line (
    .clk(clk), .rst_n(rst_n), .sel(mi_dly), .din(miso), .dout(miso_tap)
  );

  iod_tapline #(.W(1), .SEL_W(SEL_W)) u_stb_line (
    .clk(clk), .rst_n(rst_n), .sel(cap_sel), .din(smp_pre), .dout(take)
  );

  iod_capture u_cap (
    .clk(clk), .rst_n(rst_n), .take(take), .din(miso_tap),
    .bit_o(rx_bit), .vld_o(rx_valid)
  );

  AST_MOSI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(tx_shift) && mo_dly == '0) |-> mosi == $past(tx_bit)); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(tx_shift) && mo_dly == '0 && $stable(mo_dly)) |-> $stable(mosi)); // R2
  AST_EARLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_pre && cap_sel == SEL_W'(CAP_AHEAD2)) |=> rx_valid); // R4
  AST_PIN_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_pre && cap_sel == SEL_W'(CAP_AHEAD2) && mi_dly == '0) |=> rx_bit == $past(miso)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R5
endmodule

// File: tb/spi_iodelay_bench.sv
module spi_iodelay_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mo_dly = '0, mi_dly = '0, cap_sel = '0;
  logic       tx_shift = 1'b0, tx_bit = 1'b0, smp_pre = 1'b0, miso = 1'b0;
  logic       mosi, rx_bit, rx_valid;

  int checks = 0;
  int failures = 0;
  int edge_n = 0;
  bit done = 1'b0;
  logic cur_tx = 1'b0;

  typedef struct { logic b; int at; } exp_t;
  exp_t expq[$];

  spi_iodelay u_spi_iodelay (
    .clk(clk), .rst_n(rst_n), .mo_dly(mo_dly), .mi_dly(mi_dly), .cap_sel(cap_sel),
    .tx_shift(tx_shift), .tx_bit(tx_bit), .mosi(mosi), .smp_pre(smp_pre),
    .miso(miso), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic logic pin_at(int e);
    logic [31:0] v;
    v = e;
    return v[0] ^ v[2] ^ v[3];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at edge %0d", req, act, exp, edge_n);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // pin driver: level seen at edge e is pin_at(e)
  initial forever begin
    @(negedge clk);
    miso = pin_at(edge_n + 1);
  end

  // monitor / scoreboard for R3, R4, R5, R6
  initial forever begin
    @(negedge clk);
    if (rst_n && rx_valid) begin
      if (expq.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 actual=unexpected valid expected=no valid at edge %0d", edge_n);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check("R4 capture edge", 1'b1, (e.at == edge_n) ? 1'b1 : 1'b0);
        check("R3 captured bit", rx_bit, e.b);
      end
    end
  end

  task automatic run_cap(input int md, input int cs, input int n, input int gap);
    @(negedge clk);
    mi_dly = 2'(md); cap_sel = 2'(cs);
    repeat (5) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int strobe_edge;
      strobe_edge = edge_n + 1;
      e.b = pin_at(strobe_edge + cs - md);
      e.at = strobe_edge + cs;
      expq.push_back(e);
      smp_pre = 1'b1;
      @(negedge clk);
      smp_pre = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      failures++;
      $display("FAIL R6 actual=%0d pending expected=0 pending", expq.size());
      expq.delete();
    end
  endtask

  task automatic mosi_step(input int d, input logic b);
    logic old;
    @(negedge clk);
    mo_dly = 2'(d);
    repeat (5) @(negedge clk);
    old = cur_tx;
    tx_bit = b; tx_shift = 1'b1;
    @(negedge clk);
    tx_shift = 1'b0;
    for (int k = 0; k <= d + 1; k++) begin
      check("R2 mosi timing", mosi, (k >= d) ? b : old);
      tx_bit = ~tx_bit; // ignored while tx_shift low (R2)
      @(negedge clk);
    end
    check("R2 mosi ignores tx_bit", mosi, b);
    cur_tx = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mosi reset", mosi, 1'b0);
    check("R1 rx_bit reset", rx_bit, 1'b0);
    check("R1 rx_valid reset", rx_valid, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mosi after release", mosi, 1'b0);
    check("R1 rx_valid after release", rx_valid, 1'b0);

    for (int d = 0; d < 4; d++) begin
      mosi_step(d, 1'b1);
      mosi_step(d, 1'b0);
    end

    for (int md = 0; md < 4; md++)
      for (int cs = 0; cs < 4; cs++)
        run_cap(md, cs, 6, 5 + ((md + cs) % 3));

    // R6: minimum spacing with late capture
    run_cap(0, 3, 12, 4);
    run_cap(3, 3, 12, 4);
    run_cap(2, 0, 12, 4);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule